// File: doc/BRIEF.md
# Bunch-Train Hit Logger with Readout

This block is the digital sparse-readout engine for one logic column of a binary pixel sensor. Each row of the column has a group of pixels. Each pixel sends a hit flag about 150 ns long and has its own mask bit. While an acquisition window is open, the block turns each rising edge of an unmasked hit flag into a record. The record holds the pixel's index within its group and the current bunch-crossing timestamp. Records go into a small per-row memory. When several pixels in a row fire together, a priority encoder stores them one per clock, lowest index first. When a row memory is full, later hits in that row are dropped and a sticky overflow flag is set.

When the window closes, the block stops accepting hits and drains the memories onto a 30-bit parallel bus. It visits rows in ascending order, sends each row's records in the order they were stored, and then sends one status word that carries the row's record count and overflow flag. A data-valid strobe marks every word. A done flag rises after the last row and stays high until the next acquisition starts.

The control FSM has five states. `S_IDLE` is the state after reset. `S_ACQ` is the acquisition window. `S_RD_REC` emits the records of one row. `S_RD_STAT` emits that row's status word. `S_DONE` means the readout is complete.

The transitions are:
- `S_IDLE` goes to `S_ACQ` on `acq_start`.
- `S_ACQ` goes to `S_RD_REC` on `acq_stop`.
- `S_RD_REC` goes to `S_RD_STAT` when the current row has no records left.
- `S_RD_STAT` goes back to `S_RD_REC` for the next row, or to `S_DONE` after the last row.
- `S_DONE` goes to `S_ACQ` on `acq_start`.

The system chooses the clock. A slow clock suits the readout. The bunch-crossing rate reaches the block through `bx_tick`.

Top module: `hit_logger`

## Requirements
- R1: After reset, `acquiring`, `rd_valid` and `done` are all 0, and the FSM is in `S_IDLE`.
- R2: `acq_start` is accepted in `S_IDLE` or `S_DONE`. It sets `acquiring`, resets the timestamp to 0, and clears every row's record count, overflow flag and pending hits. `acq_stop` in `S_ACQ` ends acquisition and starts readout.
- R3: During acquisition, the 13-bit timestamp increments once per clock in which `bx_tick` is high, and it wraps from 8191 to 0. A record carries the timestamp value of the clock in which the record is written.
- R4: A record is made only on a rising edge of an unmasked hit flag. A flag held high across several crossings produces exactly one record.
- R5: A pixel whose bit in `mask` is 1 never produces a record.
- R6: Pixels of one row that rise together are stored one per clock in ascending pixel-index order.
- R7: Each row stores at most 19 records. A hit that arrives while the row is full is dropped, and the row's overflow flag is set.
- R8: Hit flags that change outside `S_ACQ` (in idle, during readout or after done) add no records.
- R9: Readout visits rows from 0 upward and sends each row's records in the order they were stored. A record word has bit 29 = 0, the row in bits 28:19, the pixel index in bits 18:13, and the timestamp in bits 12:0.
- R10: After each row's records comes one status word. It has bit 29 = 1, the row in bits 28:19, bits 18:9 = 0, the overflow flag in bit 8, and the record count in bits 7:0.
- R11: `done` rises in the clock after the last row's status word. It stays high with `rd_valid` low until `acq_start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_start | input | 1 | Opens an acquisition window (accepted in idle or done) |
| acq_stop | input | 1 | Closes the acquisition window and starts readout |
| bx_tick | input | 1 | One-clock strobe for each bunch crossing |
| hits | input | ROWS*PIX | Pixel hit flags; row r uses bits [r*PIX +: PIX] |
| mask | input | ROWS*PIX | Per-pixel suppress bits, laid out like `hits` |
| acquiring | output | 1 | High while in `S_ACQ` |
| rd_valid | output | 1 | Marks a valid readout word |
| rd_data | output | 30 | Readout word (record or status) |
| done | output | 1 | Readout finished |

## Verification
A wrong count, a wrong overflow flag or a corrupted memory entry in any row appears at the ports only during readout. It shows as a wrong status word or a wrong record in that row's slice of the output stream. So each train is compared word by word against a model, about two cycles per word after `acq_stop`. A timestamp counter that drifts or fails to wrap shows up in bits 12:0 of the next record written after the fault. A broken edge detector or priority order changes the number or the sequence of records within a row. Both show up in that same train's readout.

// File: rtl/hl_pkg.sv
package hl_pkg;
    localparam int TS_W      = 13;
    localparam int PIX_IDX_W = 6;
    localparam int ROW_FLD_W = 10;
    localparam int WORD_W    = 30;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACQ,
        S_RD_REC,
        S_RD_STAT,
        S_DONE
    } lg_state_t;

    function automatic logic [WORD_W-1:0] pack_rec(
        input logic [ROW_FLD_W-1:0] row,
        input logic [PIX_IDX_W-1:0] pix,
        input logic [TS_W-1:0]      ts
    );
        return {1'b0, row, pix, ts};
    endfunction

    function automatic logic [WORD_W-1:0] pack_stat(
        input logic [ROW_FLD_W-1:0] row,
        input logic                 ovf,
        input logic [7:0]           cnt
    );
        return {1'b1, row, 10'd0, ovf, cnt};
    endfunction
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
    parameter int N  = 42,
    parameter int IW = 6
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/hit_row.sv
module hit_row #(
    parameter int PIX   = 42,
    parameter int DEPTH = 19,
    parameter int TS_W  = 13,
    parameter int IDX_W = 6,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cap_en,
    input  logic [PIX-1:0]   hits,
    input  logic [PIX-1:0]   mask,
    input  logic [TS_W-1:0]  ts,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic [IDX_W-1:0] rd_pix,
    output logic [TS_W-1:0]  rd_ts
);
    logic [PIX-1:0]   prev_q;
    logic [PIX-1:0]   pend_q;
    logic [PIX-1:0]   rise;
    logic [PIX-1:0]   take_bit;
    logic [IDX_W-1:0] sel;
    logic             sel_any;
    logic             take;
    logic [IDX_W-1:0] mem_pix [DEPTH];
    logic [TS_W-1:0]  mem_ts  [DEPTH];

    assign rise     = hits & ~prev_q & ~mask & {PIX{cap_en}};
    assign take     = sel_any & cap_en;
    assign take_bit = take ? ({{(PIX-1){1'b0}}, 1'b1} << sel) : '0;

    prio_enc #(.N(PIX), .IW(IDX_W)) u_enc (
        .req (pend_q),
        .idx (sel),
        .any (sel_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            prev_q <= hits;
            if (clear) begin
                pend_q <= '0;
                cnt    <= '0;
                ovf    <= 1'b0;
            end else begin
                pend_q <= (pend_q & ~take_bit) | rise;
                if (take) begin
                    if (cnt < CNT_W'(DEPTH)) begin
                        mem_pix[cnt] <= sel;
                        mem_ts[cnt]  <= ts;
                        cnt          <= cnt + 1'b1;
                    end else begin
                        ovf <= 1'b1;
                    end
                end
            end
        end
    end

    assign rd_pix = mem_pix[rd_idx];
    assign rd_ts  = mem_ts[rd_idx];
endmodule

// File: rtl/hit_logger.sv
module hit_logger
    import hl_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int PIX   = 42,
    parameter int DEPTH = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acq_start,
    input  logic                 acq_stop,
    input  logic                 bx_tick,
    input  logic [ROWS*PIX-1:0]  hits,
    input  logic [ROWS*PIX-1:0]  mask,
    output logic                 acquiring,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 done
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    lg_state_t        state_q, state_d;
    logic [TS_W-1:0]  ts_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] rec_q;
    logic             start_ok, has_rec, last_row;

    logic [CNT_W-1:0]     cnt_a [ROWS];
    logic                 ovf_a [ROWS];
    logic [PIX_IDX_W-1:0] pix_a [ROWS];
    logic [TS_W-1:0]      ts_a  [ROWS];

    assign acquiring = (state_q == S_ACQ);
    assign start_ok  = acq_start && (state_q == S_IDLE || state_q == S_DONE);
    assign has_rec   = rec_q < cnt_a[row_q];
    assign last_row  = (row_q == ROW_W'(ROWS - 1));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        hit_row #(
            .PIX(PIX), .DEPTH(DEPTH), .TS_W(TS_W),
            .IDX_W(PIX_IDX_W), .CNT_W(CNT_W)
        ) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (start_ok),
            .cap_en (acquiring),
            .hits   (hits[r*PIX +: PIX]),
            .mask   (mask[r*PIX +: PIX]),
            .ts     (ts_q),
            .rd_idx (rec_q),
            .cnt    (cnt_a[r]),
            .ovf    (ovf_a[r]),
            .rd_pix (pix_a[r]),
            .rd_ts  (ts_a[r])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (acq_start) state_d = S_ACQ;
            S_ACQ:     if (acq_stop)  state_d = S_RD_REC;
            S_RD_REC:  if (!has_rec)  state_d = S_RD_STAT;
            S_RD_STAT: state_d = last_row ? S_DONE : S_RD_REC;
            S_DONE:    if (acq_start) state_d = S_ACQ;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register, timestamp and readout pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ts_q    <= '0;
            row_q   <= '0;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                ts_q <= '0;
            end else if (state_q == S_ACQ && bx_tick) begin
                ts_q <= ts_q + 1'b1;
            end
            if (state_q == S_ACQ && acq_stop) begin
                row_q <= '0;
                rec_q <= '0;
            end else if (state_q == S_RD_REC && has_rec) begin
                rec_q <= rec_q + 1'b1;
            end else if (state_q == S_RD_STAT && !last_row) begin
                row_q <= row_q + 1'b1;
                rec_q <= '0;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= (state_q == S_DONE) && (state_d == S_DONE);
            if (state_q == S_RD_REC && has_rec) begin
                rd_valid <= 1'b1;
                rd_data  <= pack_rec(ROW_FLD_W'(row_q), pix_a[row_q], ts_a[row_q]);
            end else if (state_q == S_RD_STAT) begin
                rd_valid <= 1'b1;
                rd_data  <= pack_stat(ROW_FLD_W'(row_q), ovf_a[row_q], 8'(cnt_a[row_q]));
            end
        end
    end
endmodule

// File: rtl/hit_logger_chk.sv
module hit_logger_chk #(
    parameter int ROWS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acq_start,
    input logic        bx_tick,
    input logic        acquiring,
    input logic        rd_valid,
    input logic [29:0] rd_data,
    input logic        done,
    input logic [12:0] ts
);
    // R3
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acquiring && bx_tick |=> ts == $past(ts) + 13'd1);

    // R8
    rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !acquiring);

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !acq_start |=> done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, rd_valid}));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && acq_start |=> acquiring && ts == 13'd0);

    // R9
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[28:19] < 10'(ROWS));
endmodule

bind hit_logger hit_logger_chk #(.ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_start (acq_start),
    .bx_tick   (bx_tick),
    .acquiring (acquiring),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .done      (done),
    .ts        (ts_q)
);

// File: tb/hit_logger_bench.sv
module hit_logger_bench;
    localparam int ROWS  = 4;
    localparam int PIX   = 42;
    localparam int DEPTH = 19;
    localparam int NP    = ROWS * PIX;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_start = 1'b0, acq_stop = 1'b0, bx_tick = 1'b0;
    logic [NP-1:0] hits = '0, mask = '0;
    logic          acquiring, rd_valid, done;
    logic [29:0]   rd_data;

    hit_logger #(.ROWS(ROWS), .PIX(PIX), .DEPTH(DEPTH)) u_hit_logger (
        .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .acq_stop(acq_stop),
        .bx_tick(bx_tick), .hits(hits), .mask(mask), .acquiring(acquiring),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    always #4 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0, bts = 0;
    bit finished = 0;
    int ecnt [ROWS];
    bit eovf [ROWS];
    logic [29:0] recs_q [$];
    logic [29:0] exp_q [$];
    logic [29:0] got_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [29:0] mk_rec(int r, int p, int t);
        return {1'b0, 10'(r), 6'(p), 13'(t)};
    endfunction

    function automatic logic [29:0] mk_stat(int r, bit o, int c);
        return {1'b1, 10'(r), 10'd0, o, 8'(c)};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_hit(int r, int p);
        if (mask[r*PIX+p]) return;
        if (ecnt[r] < DEPTH) begin
            recs_q.push_back(mk_rec(r, p, bts & 13'h1fff));
            ecnt[r]++;
        end else begin
            eovf[r] = 1'b1;
        end
    endfunction

    task automatic start_train();
        @(negedge clk) acq_start = 1'b1;
        @(negedge clk) acq_start = 1'b0;
        for (int r = 0; r < ROWS; r++) begin ecnt[r] = 0; eovf[r] = 1'b0; end
        recs_q.delete();
        bts = 0;
        @(negedge clk);
    endtask

    task automatic tick_n(int n);
        bx_tick = 1'b1;
        repeat (n) @(negedge clk);
        bx_tick = 1'b0;
        bts += n;
    endtask

    task automatic crossing(logic [NP-1:0] pat);
        for (int r = 0; r < ROWS; r++)
            for (int p = 0; p < PIX; p++)
                if (pat[r*PIX+p]) model_hit(r, p);
        hits = pat;
        repeat (3) @(negedge clk);
        hits = '0;
        repeat (50) @(negedge clk);
        tick_n(1);
    endtask

    task automatic finish_train(string tag, bit noise);
        @(negedge clk) acq_stop = 1'b1;
        @(negedge clk) acq_stop = 1'b0;
        exp_q.delete();
        got_q.delete();
        for (int r = 0; r < ROWS; r++) begin
            foreach (recs_q[i]) if (recs_q[i][28:19] == 10'(r)) exp_q.push_back(recs_q[i]);
            exp_q.push_back(mk_stat(r, eovf[r], ecnt[r]));
        end
        for (int k = 0; k < 3000; k++) begin
            if (noise) for (int b = 0; b < NP; b++) hits[b] = ($urandom % 4) == 0;
            @(negedge clk);
            if (rd_valid) got_q.push_back(rd_data);
            if (done) break;
        end
        hits = '0;
        chk(got_q.size() == exp_q.size(), {tag, " R9 word count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], {tag, exp_q[i][29] ? " R10 status word" : " R9 record word"},
                {2'b0, got_q[i]}, {2'b0, exp_q[i]});
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(done && !rd_valid, {tag, " R11 done held, no valid"}, {done, rd_valid}, 2'b10);
        end
    endtask

    function automatic logic [NP-1:0] rnd_vec(int div);
        logic [NP-1:0] v;
        for (int b = 0; b < NP; b++) v[b] = ($urandom % div) == 0;
        return v;
    endfunction

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        wait (cyc == 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] pat;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!acquiring && !rd_valid && !done, "R1 reset outputs", {acquiring, rd_valid, done}, 3'b000);

        // R8: activity in idle leaves nothing behind
        hits = rnd_vec(3);
        repeat (4) @(negedge clk);
        hits = '0;
        @(negedge clk);

        // R6: simultaneous hits in ascending order
        start_train();
        chk(acquiring, "R2 acquiring after start", acquiring, 1);
        pat = '0;
        pat[41] = 1; pat[3] = 1; pat[17] = 1;
        pat[3*PIX+40] = 1; pat[3*PIX+0] = 1;
        crossing(pat);
        finish_train("R6", 1'b0);

        // R5: masked pixels and a fully masked row
        mask = '0;
        mask[1*PIX+5] = 1;
        mask[2*PIX +: PIX] = '1;
        start_train();
        pat = '0;
        pat[1*PIX+5] = 1; pat[1*PIX+6] = 1; pat[2*PIX+0] = 1; pat[2*PIX+1] = 1;
        crossing(pat);
        finish_train("R5", 1'b0);
        mask = '0;

        // R4: a held flag gives one record, a new edge another
        start_train();
        hits[1*PIX+7] = 1'b1;
        model_hit(1, 7);
        repeat (5) @(negedge clk);
        tick_n(1);
        repeat (5) @(negedge clk);
        tick_n(1);
        repeat (5) @(negedge clk);
        hits = '0;
        repeat (3) @(negedge clk);
        pat = '0;
        pat[1*PIX+7] = 1;
        crossing(pat);
        finish_train("R4", 1'b0);

        // R7: row fills at 19, excess dropped with overflow
        start_train();
        pat = '0;
        for (int p = 0; p < 25; p++) pat[2*PIX+p] = 1;
        pat[0*PIX+9] = 1;
        crossing(pat);
        pat = '0;
        pat[2*PIX+30] = 1;
        crossing(pat);
        finish_train("R7", 1'b0);

        // R2: counts and overflow cleared on next start
        start_train();
        pat = '0;
        pat[2*PIX+33] = 1;
        crossing(pat);
        finish_train("R2", 1'b0);

        // R3: timestamp wrap
        start_train();
        tick_n(8190);
        pat = '0; pat[0*PIX+1] = 1;
        crossing(pat);
        pat = '0; pat[1*PIX+2] = 1;
        crossing(pat);
        pat = '0; pat[3*PIX+3] = 1;
        crossing(pat);
        finish_train("R3", 1'b0);

        // random trains with masks and readout noise (R8)
        for (int t = 0; t < 4; t++) begin
            mask = rnd_vec(16);
            start_train();
            for (int c = 0; c < 6; c++) begin
                crossing(rnd_vec(10));
                if (($urandom % 3) == 0) tick_n(1 + ($urandom % 5));
            end
            finish_train("R8 random", 1'b1);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule